// File: doc/BRIEF.md
# SPI Slave Word-Boundary Synchronizer

This block decides where the first valid word begins for an SPI slave receiver that may be switched on while an external master is already busy. It samples the slave-select and serial-clock pins in a faster reference clock domain and watches the enable input. It then raises a one-cycle word-start strobe and a held synchronized flag, which a downstream shift register uses to align its bit count.

There are two ways to lock. If slave-select is already active when the block is enabled, the block is partway through a frame and cannot trust the bit position. It counts reference cycles in which the serial clock does not move. A run longer than a programmable threshold marks a gap between words, and the next rising serial-clock edge starts a word. If slave-select is inactive at enable, the block waits for slave-select to fall. Slave-select must then stay low long enough to be accepted, and the first rising serial-clock edge after that starts the word. Clock polarity and phase are handled elsewhere. The active edge here is always the rising edge of the sampled clock.

Top module: `spi_wordsync`

## Requirements
- R1: While reset is held, and in the first cycle after reset, `word_start` and `synced` are both 0.
- R2: Both pins pass through two synchronizer flops before any use. A rising serial-clock transition on the pin ahead of reference edge j that is accepted as a word start shows `word_start`=1 and `synced`=1 after edge j+2, and not before.
- R3: If `ss_n_in` is high when `en` is first sampled high, the first word starts on the first rising serial-clock edge that comes after slave-select has been accepted as low.
- R4: Slave-select is accepted as low only after it has been low at the pin for at least 4 reference cycles. A rising serial-clock edge that reaches the pin 3 cycles after slave-select falls is not taken as a start, and a low pulse of 3 cycles produces no start.
- R5: If `ss_n_in` is low when the block is enabled, all serial-clock edges are ignored until two consecutive pin transitions are more than `idle_thresh` reference cycles apart. The rising transition that ends such a gap, or the first rising transition after it, starts the word.
- R6: Every sampled serial-clock transition, rising or falling, restarts the idle count from zero. The count stops at the threshold, so gaps far longer than the threshold (for example 230 cycles with a threshold of 200) are still recognised.
- R7: An `idle_thresh` of 0 behaves as 1: pin transitions one cycle apart never form a boundary, and a gap of two cycles does.
- R8: One cycle after `en` is sampled low, `synced` is 0. A later enable starts the decision again from the beginning.
- R9: `word_start` is a single-cycle pulse, given at most once per enable. `synced` stays at 1 while `en` remains high.
- R10: A slave-select fall that reaches the pin ten or more cycles after enable is handled by the rule of R3 with no false start.
- R11: If slave-select goes high while the block is still searching for a gap (R5), the search is dropped and the block waits for a new accepted slave-select fall, as in R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Enable, synchronous to `clk` |
| idle_thresh | input | 8 | Idle cycles that mark a word gap (0 behaves as 1) |
| ss_n_in | input | 1 | Slave-select pin, active low, asynchronous |
| sclk_in | input | 1 | Serial clock pin, asynchronous |
| word_start | output | 1 | One-cycle strobe at the first word's first active edge |
| synced | output | 1 | High once the word boundary is known |

## Verification
The assertions assume that `en` and `idle_thresh` change only on reference-clock edges. They also assume that `idle_thresh` does not drop below the current idle count during a search, because otherwise the saturation rule would not apply. The bench meets both conditions by changing every input at the falling reference edge and setting the threshold only while the block is disabled. It also holds each pin level for at least one full reference cycle, so every transition passes through the synchronizers and edges are never merged. The tests with a gap exactly at the threshold and one cycle past it, and with slave-select low for exactly three and four cycles, pin down the off-by-one behaviour through the synchronizer latency.

// File: rtl/spi_ws_pkg.sv
package spi_ws_pkg;
    typedef enum logic [2:0] {
        ST_OFF,
        ST_HUNT,
        ST_WAIT_SS,
        ST_ARMED,
        ST_LOCKED
    } ws_state_e;
endpackage

// File: rtl/spi_ws_sync.sv
module spi_ws_sync #(
    parameter int unsigned  W       = 2,
    parameter int unsigned  STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spi_ws_sclk_mon.sv
module spi_ws_sclk_mon #(
    parameter int unsigned IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              sclk_s,
    input  logic [IDLE_W-1:0] thr_raw,
    output logic              rise,
    output logic              idle_hit
);
    typedef struct packed {
        logic              prev;
        logic [IDLE_W-1:0] cnt;
    } mon_t;

    mon_t              mon_d, mon_q;
    logic              any_edge;
    logic [IDLE_W-1:0] thr;

    always_comb begin
        thr      = (thr_raw == '0) ? IDLE_W'(1) : thr_raw;
        any_edge = sclk_s ^ mon_q.prev;
        rise     = sclk_s & ~mon_q.prev;
        idle_hit = (mon_q.cnt >= thr);
        mon_d      = mon_q;
        mon_d.prev = sclk_s;
        if (clr || any_edge) begin
            mon_d.cnt = '0;
        end else if (mon_q.cnt < thr) begin
            mon_d.cnt = mon_q.cnt + IDLE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q <= '0;
        end else begin
            mon_q <= mon_d;
        end
    end

    // R6: any sampled transition or a clear restarts the idle run
    p_idle_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr || any_edge) |=> (mon_q.cnt == '0));

    // R6: once at the threshold with no activity the count holds
    p_idle_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !any_edge && idle_hit) |=> (mon_q.cnt == $past(mon_q.cnt)));
endmodule

// File: rtl/spi_ws_ss_qual.sv
module spi_ws_ss_qual #(
    parameter int unsigned SS_MIN_LOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ss_n_s,
    output logic ss_low,
    output logic ss_ok
);
    localparam int unsigned SSC_W = $clog2(SS_MIN_LOW + 1);

    typedef struct packed {
        logic [SSC_W-1:0] cnt;
    } qual_t;

    qual_t qual_d, qual_q;

    always_comb begin
        ss_low = ~ss_n_s;
        ss_ok  = (qual_q.cnt >= SSC_W'(SS_MIN_LOW));
        qual_d = qual_q;
        if (!ss_low) begin
            qual_d.cnt = '0;
        end else if (qual_q.cnt < SSC_W'(SS_MIN_LOW)) begin
            qual_d.cnt = qual_q.cnt + SSC_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qual_q <= '0;
        end else begin
            qual_q <= qual_d;
        end
    end

    // R4: acceptance only follows a held low level
    p_ss_rise_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_ok) |-> (ss_low && $past(ss_low)));

    // R4: a high level withdraws acceptance on the next cycle
    p_ss_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_low |=> !ss_ok);
endmodule

// File: rtl/spi_ws_fsm.sv
module spi_ws_fsm
    import spi_ws_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ss_low,
    input  logic ss_ok,
    input  logic rise,
    input  logic idle_hit,
    output logic word_start,
    output logic synced
);
    typedef struct packed {
        ws_state_e st;
        logic      ws;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d    = fsm_q;
        fsm_d.ws = 1'b0;
        unique case (fsm_q.st)
            ST_OFF: begin
                if (en) begin
                    fsm_d.st = ss_low ? ST_HUNT : ST_WAIT_SS;
                end
            end
            ST_HUNT: begin
                if (!ss_low) begin
                    fsm_d.st = ST_WAIT_SS;
                end else if (idle_hit) begin
                    if (rise) begin
                        fsm_d.st = ST_LOCKED;
                        fsm_d.ws = 1'b1;
                    end else begin
                        fsm_d.st = ST_ARMED;
                    end
                end
            end
            ST_ARMED: begin
                if (!ss_low) begin
                    fsm_d.st = ST_WAIT_SS;
                end else if (rise) begin
                    fsm_d.st = ST_LOCKED;
                    fsm_d.ws = 1'b1;
                end
            end
            ST_WAIT_SS: begin
                if (ss_ok && rise) begin
                    fsm_d.st = ST_LOCKED;
                    fsm_d.ws = 1'b1;
                end
            end
            ST_LOCKED: begin
                fsm_d.st = ST_LOCKED;
            end
            default: begin
                fsm_d.st = ST_OFF;
            end
        endcase
        if (!en) begin
            fsm_d.st = ST_OFF;
            fsm_d.ws = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{st: ST_OFF, ws: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign word_start = fsm_q.ws;
    assign synced     = (fsm_q.st == ST_LOCKED);

    // R9: the strobe lasts one cycle
    p_ws_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        word_start |=> !word_start);

    // R9: lock is held while enabled
    p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (synced && en) |=> synced);

    // R3: a start is caused by a sampled rising edge while select was low
    p_ws_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        word_start |-> ($past(rise) && $past(ss_low) && synced));

    // R8: disabling clears the outputs
    p_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!synced && !word_start));
endmodule

// File: rtl/spi_wordsync.sv
module spi_wordsync #(
    parameter int unsigned IDLE_W      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned SS_MIN_LOW  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [IDLE_W-1:0] idle_thresh,
    input  logic              ss_n_in,
    input  logic              sclk_in,
    output logic              word_start,
    output logic              synced
);
    logic [1:0] pins_s;
    logic       ss_low, ss_ok, rise, idle_hit;

    spi_ws_sync #(
        .W       (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b10)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ss_n_in, sclk_in}),
        .q     (pins_s)
    );

    spi_ws_sclk_mon #(
        .IDLE_W (IDLE_W)
    ) u_sclk_mon (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (~en),
        .sclk_s   (pins_s[0]),
        .thr_raw  (idle_thresh),
        .rise     (rise),
        .idle_hit (idle_hit)
    );

    spi_ws_ss_qual #(
        .SS_MIN_LOW (SS_MIN_LOW)
    ) u_ss_qual (
        .clk    (clk),
        .rst_n  (rst_n),
        .ss_n_s (pins_s[1]),
        .ss_low (ss_low),
        .ss_ok  (ss_ok)
    );

    spi_ws_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .ss_low     (ss_low),
        .ss_ok      (ss_ok),
        .rise       (rise),
        .idle_hit   (idle_hit),
        .word_start (word_start),
        .synced     (synced)
    );

    // R2: a start needs the sampled clock to have been low one cycle earlier
    p_start_after_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_start) |-> $past(rise));
endmodule

// File: tb/spi_wordsync_bench.sv
module spi_wordsync_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] idle_thresh = 8'd8;
    logic       ss_n_in = 1'b1;
    logic       sclk_in = 1'b0;
    logic       word_start, synced;

    int n_run  = 0;
    int n_fail = 0;
    int ws_cnt = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    spi_wordsync u_spi_wordsync (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .idle_thresh (idle_thresh),
        .ss_n_in     (ss_n_in),
        .sclk_in     (sclk_in),
        .word_start  (word_start),
        .synced      (synced)
    );

    always @(negedge clk) if (word_start) ws_cnt <= ws_cnt + 1;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // drive a rising clock edge now; the result is due three edges later
    task automatic rise_expect(input int exp, input string tag);
        sclk_in = 1'b1;
        tick(2);
        chk({tag, " early"}, int'(word_start), 0);
        tick(1);
        chk({tag, " strobe"}, int'(word_start), exp);
        chk({tag, " synced"}, int'(synced), exp);
    endtask

    task automatic clean(input logic [7:0] thr, input logic ss_lvl);
        en = 1'b0;
        idle_thresh = thr;
        sclk_in = 1'b0;
        ss_n_in = ss_lvl;
        tick(5);
        chk("R8 idle when disabled", int'(synced), 0);
    endtask

    task automatic t_reset;
        tick(3);
        chk("R1 strobe in reset", int'(word_start), 0);
        chk("R1 synced in reset", int'(synced), 0);
        rst_n = 1'b1;
        tick(1);
        chk("R1 synced after reset", int'(synced), 0);
    endtask

    task automatic t_ss_start;
        int base;
        clean(8'd8, 1'b1);
        en = 1'b1;
        tick(10);
        ss_n_in = 1'b0;
        tick(4);
        base = ws_cnt;
        rise_expect(1, "R3 R10 R2");
        for (int i = 0; i < 6; i++) begin
            sclk_in = ~sclk_in;
            tick(2);
        end
        tick(2);
        chk("R9 single pulse", ws_cnt - base, 1);
        chk("R9 lock held", int'(synced), 1);
    endtask

    task automatic t_disable;
        en = 1'b0;
        tick(1);
        chk("R8 synced cleared", int'(synced), 0);
        ss_n_in = 1'b1;
        sclk_in = 1'b0;
        tick(3);
        en = 1'b1;
        tick(6);
        chk("R8 re-enable waits", int'(synced), 0);
        ss_n_in = 1'b0;
        tick(4);
        rise_expect(1, "R8 relock");
    endtask

    task automatic t_ss_min;
        int base;
        clean(8'd8, 1'b1);
        en = 1'b1;
        tick(10);
        base = ws_cnt;
        ss_n_in = 1'b0;
        tick(2);
        sclk_in = 1'b1;
        tick(1);
        ss_n_in = 1'b1;
        tick(8);
        chk("R4 short low pulse", ws_cnt - base, 0);
        chk("R4 short low synced", int'(synced), 0);
        sclk_in = 1'b0;
        tick(4);
        ss_n_in = 1'b0;
        tick(3);
        rise_expect(0, "R4 edge too soon");
        sclk_in = 1'b0;
        tick(2);
        rise_expect(1, "R4 later edge");
    endtask

    task automatic t_idle_gap;
        int base;
        clean(8'd6, 1'b0);
        base = ws_cnt;
        for (int i = 0; i < 10; i++) begin
            sclk_in = ~sclk_in;
            if (i == 3) en = 1'b1;
            tick(6);
        end
        chk("R5 gap equal to threshold ignored", ws_cnt - base, 0);
        chk("R6 edges restart count", int'(synced), 0);
        tick(1);
        rise_expect(1, "R5 gap past threshold");
    endtask

    task automatic t_thr_zero;
        int base;
        clean(8'd0, 1'b0);
        base = ws_cnt;
        for (int i = 0; i < 20; i++) begin
            sclk_in = ~sclk_in;
            if (i == 4) en = 1'b1;
            tick(1);
        end
        chk("R7 one-cycle gaps ignored", ws_cnt - base, 0);
        tick(1);
        rise_expect(1, "R7 two-cycle gap");
    endtask

    task automatic t_saturate;
        clean(8'd200, 1'b0);
        for (int i = 0; i < 8; i++) begin
            sclk_in = ~sclk_in;
            if (i == 3) en = 1'b1;
            tick(3);
        end
        tick(120);
        chk("R6 no boundary yet", int'(synced), 0);
        tick(107);
        rise_expect(1, "R6 long gap");
    endtask

    task automatic t_hunt_abort;
        clean(8'd200, 1'b0);
        for (int i = 0; i < 10; i++) begin
            sclk_in = ~sclk_in;
            if (i == 3) en = 1'b1;
            tick(2);
        end
        ss_n_in = 1'b1;
        tick(10);
        chk("R11 not locked", int'(synced), 0);
        ss_n_in = 1'b0;
        tick(4);
        rise_expect(1, "R11 restart via select");
    endtask

    initial begin
        t_reset();
        t_ss_start();
        t_disable();
        t_ss_min();
        t_idle_gap();
        t_thr_zero();
        t_saturate();
        t_hunt_abort();
        tick(2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule